// File: doc/BRIEF.md
# Adaptive Dead-Time Half-Bridge Sequencer

This block is the digital sequencing core of a synchronous half-bridge gate driver. It takes one PWM level and an active-high enable and produces two gate commands, one for the high-side switch and one for the low-side switch. The high-side command follows PWM and the low-side command follows its inverse. Each turn-on is held back until the opposite switch is sensed to be off, so the two switches never conduct at the same time.

Three comparator results arrive as digital flags: low-side gate below threshold, switch node below threshold, and high-side gate-source below threshold. Each flag passes through a two-flop synchronizer. After the relevant flag is seen, a programmable delay in clock cycles must run out before the turn-on happens. A second, longer timer starts from the high-side gate-source flag. It turns the low side on even when the switch node never drops, for example while the converter is sinking current. The secondary delay is formed as the primary low-side delay plus a margin of at least one cycle, so it is always the longer of the two.

Top module: `hb_deadtime_ctrl`

## Requirements
- R1: `hs_on` and `ls_on` are never high in the same cycle.
- R2: While `en` is low, both commands are low, including in the same cycle that `en` falls. No flag or PWM activity changes this.
- R3: After reset, and after `en` rises, both commands stay low in the first cycle. The first sampled PWM level then starts the normal interlock sequence; neither command turns on directly.
- R4: When PWM rises with `en` high, `ls_on` is low from the next cycle on.
- R5: In the high-side turn-on phase, a `lsg_low` assertion at cycle n raises `hs_on` at cycle n+3+HS_DLY (two synchronizer flops, one timer-start cycle, then HS_DLY counts). If the synchronized flag is already high when the phase begins, the turn-on comes one cycle after the delay is met.
- R6: When PWM falls with `en` high, `hs_on` is low from the next cycle on.
- R7: In the low-side turn-on phase, a `sw_low` assertion at cycle n raises `ls_on` at cycle n+3+LS_DLY.
- R8: In the low-side turn-on phase, a `hsg_low` assertion at cycle n raises `ls_on` at cycle n+3+LS_DLY+SEC_MARGIN, whatever the state of `sw_low`.
- R9: When both low-side flags assert together, the primary path sets the turn-on time (n+3+LS_DLY).
- R10: If PWM reverses while a turn-on delay is running, that turn-on is cancelled. The new direction's sequence starts from the beginning and waits for its own flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all delays are counted in its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Active-high enable; low forces both commands off |
| pwm | input | 1 | Synchronous PWM level |
| lsg_low | input | 1 | Low-side gate below threshold (asynchronous) |
| sw_low | input | 1 | Switch node below threshold (asynchronous) |
| hsg_low | input | 1 | High-side gate-source below threshold (asynchronous) |
| hs_on | output | 1 | High-side gate command |
| ls_on | output | 1 | Low-side gate command |

## Verification
The hardest situations to reach from the ports are the cancellations. In these, PWM reverses after a flag has already started a turn-on timer but before the timer runs out. The stimulus places the reversal a fixed number of cycles after the flag, counted from the synchronizer and timer latency, so that it lands inside the counting window. The bench then confirms that the command stays low past the cycle where it would have risen. It also drives the secondary path in isolation by holding the switch-node flag low, and it re-enables the block with a flag that is already stale-high to check the re-entry timing.

// File: rtl/hb_dt_pkg.sv
package hb_dt_pkg;

  // Flag bit positions: each bit also selects the timer it starts
  localparam int unsigned FLG_LSG = 0;
  localparam int unsigned FLG_SW  = 1;
  localparam int unsigned FLG_HSG = 2;
  localparam int unsigned FLG_N   = 3;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RISE = 3'd1,
    ST_HS   = 3'd2,
    ST_FALL = 3'd3,
    ST_LS   = 3'd4
  } hb_state_e;

endpackage

// File: rtl/hb_flag_sync.sv
module hb_flag_sync #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic meta_q;
    logic stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= async_i[b];
        stab_q <= meta_q;
      end
    end
    assign sync_o[b] = stab_q;
  end

endmodule

// File: rtl/hb_delay_timer.sv
module hb_delay_timer #(
  parameter int unsigned DLY = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic start,
  output logic done
);

  localparam int unsigned CW = $clog2(DLY + 1);
  localparam logic [CW-1:0] TERM = CW'(DLY);

  logic          run_q, run_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    if (clr) begin
      run_d = 1'b0;
      cnt_d = '0;
    end else if (!run_q) begin
      if (start) begin
        run_d = 1'b1;
        cnt_d = CW'(1);
      end
    end else if (cnt_q != TERM) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  assign done = run_q && (cnt_q == TERM);

endmodule

// File: rtl/hb_seq_fsm.sv
module hb_seq_fsm
  import hb_dt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  logic      pwm,
  input  logic      hs_go,
  input  logic      ls_go,
  output hb_state_e state,
  output logic      hs_on,
  output logic      ls_on
);

  hb_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!en) begin
      st_d = ST_IDLE;
    end else begin
      unique case (st_q)
        ST_IDLE: st_d = pwm ? ST_RISE : ST_FALL;
        ST_RISE: begin
          if (!pwm)      st_d = ST_FALL;
          else if (hs_go) st_d = ST_HS;
        end
        ST_HS:   if (!pwm) st_d = ST_FALL;
        ST_FALL: begin
          if (pwm)        st_d = ST_RISE;
          else if (ls_go) st_d = ST_LS;
        end
        ST_LS:   if (pwm) st_d = ST_RISE;
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign state = st_q;
  // enable gates the decoded commands so a disable takes effect at once
  assign hs_on = en && (st_q == ST_HS);
  assign ls_on = en && (st_q == ST_LS);

endmodule

// File: rtl/hb_deadtime_ctrl.sv
module hb_deadtime_ctrl
  import hb_dt_pkg::*;
#(
  parameter int unsigned HS_DLY     = 4,
  parameter int unsigned LS_DLY     = 3,
  parameter int unsigned SEC_MARGIN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic pwm,
  input  logic lsg_low,
  input  logic sw_low,
  input  logic hsg_low,
  output logic hs_on,
  output logic ls_on
);

  localparam int unsigned SEC_DLY = LS_DLY + ((SEC_MARGIN == 0) ? 1 : SEC_MARGIN);

  function automatic int unsigned dly_of(input int unsigned idx);
    case (idx)
      FLG_LSG: return HS_DLY;
      FLG_SW:  return LS_DLY;
      default: return SEC_DLY;
    endcase
  endfunction

  logic [FLG_N-1:0] flg_raw, flg_s, tmr_clr, tmr_done;
  hb_state_e        state;

  assign flg_raw = {hsg_low, sw_low, lsg_low};

  hb_flag_sync #(.W(FLG_N)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (flg_raw),
    .sync_o  (flg_s)
  );

  // timer i is started by flag i; it is cleared outside its own phase
  for (genvar i = 0; i < FLG_N; i++) begin : g_tmr
    if (i == FLG_LSG) begin : g_rise
      assign tmr_clr[i] = (state != ST_RISE);
    end else begin : g_fall
      assign tmr_clr[i] = (state != ST_FALL);
    end
    hb_delay_timer #(.DLY(dly_of(i))) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tmr_clr[i]),
      .start (flg_s[i]),
      .done  (tmr_done[i])
    );
  end

  hb_seq_fsm u_fsm (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (en),
    .pwm   (pwm),
    .hs_go (tmr_done[FLG_LSG]),
    .ls_go (tmr_done[FLG_SW] || tmr_done[FLG_HSG]),
    .state (state),
    .hs_on (hs_on),
    .ls_on (ls_on)
  );

endmodule

// File: rtl/hb_deadtime_ctrl_chk.sv
module hb_deadtime_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic pwm,
  input logic hs_on,
  input logic ls_on
);

  // R1
  excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_on && ls_on));

  // R2
  dis_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!hs_on && !ls_on));

  // R3
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |=> (!hs_on && !ls_on));

  // R4
  ls_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $rose(pwm)) |=> !ls_on);

  // R6
  hs_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwm) |=> !hs_on);

  // R5
  hs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_on) |-> ($past(pwm) && !$past(ls_on)));

  // R7
  ls_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls_on) |-> (!$past(pwm) && !$past(hs_on)));

endmodule

bind hb_deadtime_ctrl hb_deadtime_ctrl_chk u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .en    (en),
  .pwm   (pwm),
  .hs_on (hs_on),
  .ls_on (ls_on)
);

// File: tb/tb_hb_deadtime_ctrl.sv
module tb_hb_deadtime_ctrl;

  localparam int unsigned HS_DLY = 3;
  localparam int unsigned LS_DLY = 2;
  localparam int unsigned MARGIN = 4;
  localparam int unsigned SEC    = LS_DLY + MARGIN;

  logic clk = 1'b0;
  logic rst_n, en, pwm, lsg_low, sw_low, hsg_low;
  logic hs_on, ls_on;

  hb_deadtime_ctrl #(.HS_DLY(HS_DLY), .LS_DLY(LS_DLY), .SEC_MARGIN(MARGIN)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .pwm(pwm),
    .lsg_low(lsg_low), .sw_low(sw_low), .hsg_low(hsg_low),
    .hs_on(hs_on), .ls_on(ls_on)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    cyc;
    bit    hs;
    bit    ls;
    string req;
  } exp_t;

  exp_t sbq[$];
  int   n_vec = 0;
  int   n_bad = 0;
  bit   fin   = 1'b0;

  task automatic push_exp(input int c, input bit h, input bit l, input string r);
    exp_t e;
    e.cyc = c; e.hs = h; e.ls = l; e.req = r;
    sbq.push_back(e);
  endtask

  task automatic at_cyc(input int c);
    while (cyc < c) begin
      @(posedge clk);
      #2;
    end
  endtask

  // monitor: compares scoreboard items at the falling edge of their cycle
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
      exp_t e;
      e = sbq.pop_front();
      n_vec++;
      if (e.cyc != cyc) begin
        n_bad++;
        $display("FAIL %s cyc %0d: item missed (now cyc %0d)", e.req, e.cyc, cyc);
      end else if (hs_on !== e.hs || ls_on !== e.ls) begin
        n_bad++;
        $display("FAIL %s cyc %0d: hs/ls actual %b%b expected %b%b",
                 e.req, cyc, hs_on, ls_on, e.hs, e.ls);
      end else if (hs_on && ls_on) begin
        n_bad++;
        $display("FAIL R1 cyc %0d: hs/ls actual 11 expected not both", cyc);
      end
    end
  end

  initial begin
    #20us;
    if (!fin) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; en = 1'b1; pwm = 1'b0;
    lsg_low = 1'b0; sw_low = 1'b0; hsg_low = 1'b0;
    push_exp(1, 0, 0, "R3");
    push_exp(2, 0, 0, "R3");
    at_cyc(3);
    rst_n = 1'b1;
    push_exp(4, 0, 0, "R3");
    push_exp(6, 0, 0, "R3");

    // R7: primary low-side turn-on after switch-node flag
    at_cyc(8);  sw_low = 1'b1;
    push_exp(8 + 2 + LS_DLY, 0, 0, "R7");
    push_exp(8 + 3 + LS_DLY, 0, 1, "R7");

    // R4 then R5: rising edge, low side drops, high side waits for flag
    at_cyc(15); pwm = 1'b1; sw_low = 1'b0;
    push_exp(16, 0, 0, "R4");
    at_cyc(18); lsg_low = 1'b1;
    push_exp(18 + 2 + HS_DLY, 0, 0, "R5");
    push_exp(18 + 3 + HS_DLY, 1, 0, "R5");

    // R6 then R8: falling edge, secondary path only
    at_cyc(27); pwm = 1'b0; lsg_low = 1'b0;
    push_exp(28, 0, 0, "R6");
    at_cyc(29); hsg_low = 1'b1;
    push_exp(29 + 3 + LS_DLY, 0, 0, "R8");
    push_exp(29 + 2 + SEC, 0, 0, "R8");
    push_exp(29 + 3 + SEC, 0, 1, "R8");

    // R9: both low-side flags together, primary timing wins
    at_cyc(41); pwm = 1'b1; hsg_low = 1'b0; lsg_low = 1'b1;
    push_exp(42, 0, 0, "R4");
    push_exp(41 + 3 + HS_DLY, 1, 0, "R5");
    at_cyc(50); pwm = 1'b0; lsg_low = 1'b0; sw_low = 1'b1; hsg_low = 1'b1;
    push_exp(51, 0, 0, "R6");
    push_exp(50 + 2 + LS_DLY, 0, 0, "R9");
    push_exp(50 + 3 + LS_DLY, 0, 1, "R9");

    // R10: cancel a pending high-side turn-on
    at_cyc(58); pwm = 1'b1; sw_low = 1'b0; hsg_low = 1'b0; lsg_low = 1'b1;
    at_cyc(61); pwm = 1'b0; lsg_low = 1'b0;
    push_exp(62, 0, 0, "R10");
    push_exp(58 + 3 + HS_DLY, 0, 0, "R10");
    push_exp(66, 0, 0, "R10");
    push_exp(68, 0, 0, "R10");
    at_cyc(70); sw_low = 1'b1;
    push_exp(70 + 3 + LS_DLY, 0, 1, "R10");

    // R10: cancel a pending low-side turn-on
    at_cyc(78); pwm = 1'b1;
    push_exp(79, 0, 0, "R4");
    at_cyc(80); pwm = 1'b0;
    at_cyc(82); pwm = 1'b1; sw_low = 1'b0;
    push_exp(83, 0, 0, "R10");
    push_exp(84, 0, 0, "R10");
    push_exp(86, 0, 0, "R10");
    push_exp(88, 0, 0, "R10");

    // R2: disable while high side is on, flags active during disable
    at_cyc(90); lsg_low = 1'b1;
    push_exp(90 + 3 + HS_DLY, 1, 0, "R5");
    at_cyc(100); en = 1'b0;
    push_exp(100, 0, 0, "R2");
    at_cyc(101); pwm = 1'b0; sw_low = 1'b1; hsg_low = 1'b1;
    push_exp(104, 0, 0, "R2");
    push_exp(110, 0, 0, "R2");

    // R3: re-enable with a stale-high flag goes through the interlock
    at_cyc(112); pwm = 1'b1; en = 1'b1; sw_low = 1'b0; hsg_low = 1'b0;
    push_exp(113, 0, 0, "R3");
    push_exp(112 + 1 + HS_DLY, 0, 0, "R3");
    push_exp(112 + 2 + HS_DLY, 1, 0, "R3");

    at_cyc(125);
    fin = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule